// File: doc/BRIEF.md
# Pseudo-static RAM refresh controller

This block is the refresh and mode-control logic that sits beside the DRAM cell array of a pseudo-static RAM. It samples the chip-select, write and output-enable/refresh pins once per clock and decodes them into an operating mode. From that mode it produces a one-cycle row strobe to the array, a select for the external/internal row-address multiplexer, and read and write enables for the data path. An 8-bit internal row counter supplies the row during refresh cycles that carry no address.

The output-enable pin doubles as the refresh clock. While chip select is high, each new low level on that pin refreshes one counter row. When the low level is held for a parameterised number of cycles, the block switches to self refresh. A local timer then strobes one row at a fixed interval until the pin rises. A refresh condition that appears while an access holds chip select low is deferred: it fires on the cycle that chip select rises, if the pin is still low then.

After reset the block does no work until a power-up wait and a set of dummy cycles are complete. The defaults assume a 50 MHz clock: 400 cycles is 8 µs, one self-refresh row every 700 cycles is 14 µs, and 10000 cycles is 200 µs.

Top module: `psram_ref_ctrl`

## Requirements
- R1: During and straight after reset, mode_o is 0 (initialising), the row counter is 0, and row_stb_o, int_sel_o, rd_o, wr_o, self_o and init_done_o are all low.
- R2: init_done_o rises only after POWERUP_CYC consecutive sampled cycles with cs_n_i and oe_ref_n_i both high, followed by DUMMY_CNT falling edges of cs_n_i. A low on either pin during the wait restarts the wait. Before init_done_o is high there are no strobes and no rd_o or wr_o. After it rises, init_done_o stays high.
- R3: mode_o codes are 0 init, 1 standby, 2 write, 3 read, 4 chip-select-only refresh, 5 auto refresh, 6 self refresh. With cs_n_i low, the mode is write if we_n_i is low, read if oe_ref_n_i is low, and otherwise chip-select-only refresh. With cs_n_i high, the mode is auto or self if oe_ref_n_i is low, and standby otherwise.
- R4: Each falling edge of cs_n_i after init gives exactly one row_stb_o cycle. In that cycle int_sel_o is low and row_o equals addr_i[7:0]. col_o always equals addr_i[14:8].
- R5: Each start of the refresh condition (cs_n_i high, oe_ref_n_i low) gives one row_stb_o cycle. In that cycle int_sel_o is high and row_o is the counter value. The counter advances by one, modulo 256, after every internal-row strobe and at no other time.
- R6: Once the refresh condition has been held for LONG_CYC sampled cycles, self_o is high and mode_o is 6. Further strobes come every SELF_INT cycles, the first on held cycle LONG_CYC+SELF_INT-1. Self refresh ends when oe_ref_n_i rises.
- R7: oe_ref_n_i going low while cs_n_i is low is a read and gives no internal strobe. If cs_n_i then rises while oe_ref_n_i is still low, an auto-refresh strobe occurs on that cycle.
- R8: Every output reflects the pins sampled at the most recent rising clock edge, so there is one register of latency.
- R9: wr_o is high in write mode and rd_o in read mode, both only after init. rd_o, wr_o and int_sel_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write command, low writes |
| oe_ref_n_i | input | 1 | Output enable / refresh clock, active low |
| addr_i | input | 15 | Address, row in bits 7:0, column in bits 14:8 |
| mode_o | output | 3 | Decoded operating mode |
| init_done_o | output | 1 | Power-up sequence complete |
| row_stb_o | output | 1 | One-cycle row activate/refresh strobe |
| int_sel_o | output | 1 | Row mux selects the internal counter |
| row_o | output | 8 | Row address to the array |
| col_o | output | 7 | Column address to the array |
| rd_o | output | 1 | Read data path enable |
| wr_o | output | 1 | Write data path enable |
| self_o | output | 1 | Self refresh active |

## Verification
A wrong row counter value shows on row_o in the cycle of the next internal strobe, which can be one refresh pulse away or a full self-refresh interval away. A pulse-width count that is off by one moves the self_o rise and every later timed strobe by one cycle. A lost hold-off shows as a missing strobe in the cycle that chip select rises. A stuck initialisation state shows as strobes or enables before the dummy edges are complete, or as init_done_o never rising. The reference model is compared against every output on every clock, so each of these faults is reported in the first cycle it becomes visible.

// File: rtl/psram_ref_pkg.sv
package psram_ref_pkg;
  typedef enum logic [2:0] {
    MODE_INIT    = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_WRITE   = 3'd2,
    MODE_READ    = 3'd3,
    MODE_CE_REF  = 3'd4,
    MODE_AUTO    = 3'd5,
    MODE_SELF    = 3'd6
  } mode_e;
endpackage

// File: rtl/psram_ref_init.sv
module psram_ref_init #(
  parameter int POWERUP_CYC = 10000,
  parameter int DUMMY_CNT   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic oe_n_i,
  input  logic cs_fall_i,
  output logic done_o
);
  localparam int HW = $clog2(POWERUP_CYC + 1);
  localparam int DW = $clog2(DUMMY_CNT + 1);
  localparam logic [HW-1:0] HI_MAX  = HW'(POWERUP_CYC);
  localparam logic [DW-1:0] DUM_MAX = DW'(DUMMY_CNT);

  logic [HW-1:0] hi_q;
  logic [DW-1:0] dum_q;
  logic          wait_done;

  assign wait_done = (hi_q == HI_MAX);
  assign done_o    = wait_done && (dum_q == DUM_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      dum_q <= '0;
    end else if (!wait_done) begin
      // any low pin restarts the quiet period
      hi_q <= (cs_n_i && oe_n_i) ? hi_q + 1'b1 : '0;
    end else if (!done_o && cs_fall_i) begin
      dum_q <= dum_q + 1'b1;
    end
  end
endmodule

// File: rtl/psram_ref_timer.sv
module psram_ref_timer #(
  parameter int LONG_CYC = 400,
  parameter int SELF_INT = 700
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic start_o,
  output logic self_o,
  output logic tick_o
);
  localparam int WW = $clog2(LONG_CYC + 1);
  localparam int TW = $clog2(SELF_INT + 1);
  localparam logic [WW-1:0] W_MAX = WW'(LONG_CYC);
  localparam logic [TW-1:0] T_MAX = TW'(SELF_INT - 1);

  logic          prev_q;
  logic [WW-1:0] w_q, w_nxt;
  logic [TW-1:0] t_q;

  always_comb begin
    if (!cond_i)            w_nxt = '0;
    else if (!prev_q)       w_nxt = WW'(1);
    else if (w_q == W_MAX)  w_nxt = W_MAX;
    else                    w_nxt = w_q + 1'b1;
  end

  assign start_o = cond_i && !prev_q;
  assign self_o  = cond_i && (w_nxt == W_MAX);
  assign tick_o  = self_o && (t_q == T_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      w_q    <= '0;
      t_q    <= '0;
    end else begin
      prev_q <= cond_i;
      w_q    <= w_nxt;
      if (!self_o || tick_o) t_q <= '0;
      else                   t_q <= t_q + 1'b1;
    end
  end
endmodule

// File: rtl/psram_ref_rowctr.sv
module psram_ref_rowctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             int_sel_i,
  input  logic [ROW_W-1:0] ext_row_i,
  output logic [ROW_W-1:0] row_o,
  output logic [ROW_W-1:0] cnt_o
);
  logic [ROW_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign row_o = int_sel_i ? cnt_q : ext_row_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psram_ref_ctrl.sv
module psram_ref_ctrl
  import psram_ref_pkg::*;
#(
  parameter int ROW_W       = 8,
  parameter int COL_W       = 7,
  parameter int LONG_CYC    = 400,
  parameter int SELF_INT    = 700,
  parameter int POWERUP_CYC = 10000,
  parameter int DUMMY_CNT   = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_n_i,
  input  logic                   we_n_i,
  input  logic                   oe_ref_n_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  output logic [2:0]             mode_o,
  output logic                   init_done_o,
  output logic                   row_stb_o,
  output logic                   int_sel_o,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o,
  output logic                   rd_o,
  output logic                   wr_o,
  output logic                   self_o
);
  localparam int ADDR_W = ROW_W + COL_W;

  logic              cs_n_q, we_n_q, oe_n_q, cs_prev_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cs_fall, acc_start, ref_cond;
  logic              ref_start, self_act, self_tick, init_done;
  logic [ROW_W-1:0]  row_cnt;
  mode_e             mode;

  // single sampling stage on all pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      cs_prev_q <= 1'b1;
      addr_q    <= '0;
    end else begin
      cs_n_q    <= cs_n_i;
      we_n_q    <= we_n_i;
      oe_n_q    <= oe_ref_n_i;
      cs_prev_q <= cs_n_q;
      addr_q    <= addr_i;
    end
  end

  assign cs_fall   = !cs_n_q && cs_prev_q;
  assign acc_start = init_done && cs_fall;
  // condition edge also covers cs rising while refresh pin low (hold-off)
  assign ref_cond  = init_done && cs_n_q && !oe_n_q;

  psram_ref_init #(
    .POWERUP_CYC(POWERUP_CYC),
    .DUMMY_CNT  (DUMMY_CNT)
  ) u_init (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_i   (cs_n_q),
    .oe_n_i   (oe_n_q),
    .cs_fall_i(cs_fall),
    .done_o   (init_done)
  );

  psram_ref_timer #(
    .LONG_CYC(LONG_CYC),
    .SELF_INT(SELF_INT)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (ref_cond),
    .start_o(ref_start),
    .self_o (self_act),
    .tick_o (self_tick)
  );

  psram_ref_rowctr #(
    .ROW_W(ROW_W)
  ) u_row (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (ref_start || self_tick),
    .int_sel_i(ref_cond),
    .ext_row_i(addr_q[ROW_W-1:0]),
    .row_o    (row_o),
    .cnt_o    (row_cnt)
  );

  always_comb begin
    if (!init_done)     mode = MODE_INIT;
    else if (!cs_n_q) begin
      if (!we_n_q)      mode = MODE_WRITE;
      else if (!oe_n_q) mode = MODE_READ;
      else              mode = MODE_CE_REF;
    end
    else if (!oe_n_q)   mode = self_act ? MODE_SELF : MODE_AUTO;
    else                mode = MODE_STANDBY;
  end

  assign mode_o      = mode;
  assign init_done_o = init_done;
  assign row_stb_o   = acc_start || ref_start || self_tick;
  assign int_sel_o   = ref_cond;
  assign col_o       = addr_q[ADDR_W-1:ROW_W];
  assign rd_o        = (mode == MODE_READ);
  assign wr_o        = (mode == MODE_WRITE);
  assign self_o      = self_act;
endmodule

// File: rtl/psram_ref_ctrl_chk.sv
module psram_ref_ctrl_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_o,
  input logic             init_done_o,
  input logic             row_stb_o,
  input logic             int_sel_o,
  input logic             rd_o,
  input logic             wr_o,
  input logic             self_o,
  input logic [ROW_W-1:0] row_cnt
);
  // R2
  stb_needs_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_stb_o || rd_o || wr_o) |-> init_done_o);
  // R2
  init_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  // R5
  row_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_stb_o && int_sel_o) |=> (row_cnt == ROW_W'($past(row_cnt) + 1'b1)));
  // R5
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(row_stb_o && int_sel_o) |=> $stable(row_cnt));
  // R9
  path_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_o, wr_o, int_sel_o}));
  // R6
  self_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_o |-> (int_sel_o && mode_o == 3'd6));
  // R3
  init_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (mode_o != 3'd0));
endmodule

bind psram_ref_ctrl psram_ref_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_o     (mode_o),
  .init_done_o(init_done_o),
  .row_stb_o  (row_stb_o),
  .int_sel_o  (int_sel_o),
  .rd_o       (rd_o),
  .wr_o       (wr_o),
  .self_o     (self_o),
  .row_cnt    (row_cnt)
);

// File: tb/psram_ref_ctrl_tb.sv
`timescale 1ns/1ps
module psram_ref_ctrl_tb;
  localparam int ROW_W = 8, COL_W = 7;
  localparam int LONG  = 12, SINT = 5, PWR = 20, DUM = 8;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, we_n = 1, oe_n = 1;
  logic [14:0] addr = '0;
  logic [2:0] mode;
  logic done, stb, isel, rd, wr, slf;
  logic [7:0] row;
  logic [6:0] col;

  int n_cmp = 0, n_bad = 0, stb_cnt = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  psram_ref_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .LONG_CYC(LONG), .SELF_INT(SINT),
                   .POWERUP_CYC(PWR), .DUMMY_CNT(DUM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .we_n_i(we_n), .oe_ref_n_i(oe_n),
    .addr_i(addr), .mode_o(mode), .init_done_o(done), .row_stb_o(stb),
    .int_sel_o(isel), .row_o(row), .col_o(col), .rd_o(rd), .wr_o(wr), .self_o(slf));

  // reference model state
  int m_prev_ce = 1, m_prev_cond = 0, m_w = 0, m_t = 0, m_row = 0, m_hi = 0, m_dum = 0;
  int e_mode, e_done, e_stb, e_isel, e_row, e_col, e_rd, e_wr, e_slf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_ce = 1; m_prev_cond = 0; m_w = 0; m_t = 0; m_row = 0; m_hi = 0; m_dum = 0;
    end else begin
      int ce, we, oe, dn, cond, acc, st, wv, sf, tk, fall;
      ce = cs_n; we = we_n; oe = oe_n;
      dn = (m_hi == PWR && m_dum == DUM);
      fall = (!ce && m_prev_ce);
      cond = dn && ce && !oe;
      acc = dn && fall;
      st = cond && !m_prev_cond;
      wv = !cond ? 0 : (!m_prev_cond ? 1 : (m_w + 1 > LONG ? LONG : m_w + 1));
      sf = cond && wv == LONG;
      tk = sf && m_t == SINT - 1;
      e_done = dn; e_stb = acc || st || tk; e_isel = cond; e_slf = sf;
      e_row = cond ? m_row : addr[7:0];
      e_col = addr[14:8];
      if (!dn) e_mode = 0;
      else if (!ce) e_mode = !we ? 2 : (!oe ? 3 : 4);
      else if (!oe) e_mode = sf ? 6 : 5;
      else e_mode = 1;
      e_rd = (e_mode == 3); e_wr = (e_mode == 2);
      m_w = wv;
      m_t = (sf && !tk) ? m_t + 1 : 0;
      if (st || tk) m_row = (m_row + 1) % 256;
      if (m_hi != PWR) m_hi = (ce && oe) ? m_hi + 1 : 0;
      else if (!dn && fall) m_dum++;
      m_prev_cond = cond; m_prev_ce = ce;
      model_on = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk("R3 mode", mode, e_mode);
      chk("R2 init_done", done, e_done);
      chk("R4 row_stb", stb, e_stb);
      chk("R7 int_sel", isel, e_isel);
      chk("R5 row", row, e_row);
      chk("R4 col", col, e_col);
      chk("R9 rd", rd, e_rd);
      chk("R9 wr", wr, e_wr);
      chk("R6 self", slf, e_slf);
      if (stb) stb_cnt++;
    end
  end

  task automatic idle(int n);
    cs_n = 1; we_n = 1; oe_n = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic access(int kind, logic [14:0] a, int len);
    cs_n = 0; addr = a;
    we_n = (kind == 0) ? 1'b0 : 1'b1;
    oe_n = (kind == 1) ? 1'b0 : 1'b1;
    repeat (len) @(negedge clk);
    idle(2);
  endtask

  task automatic refresh(int len);
    cs_n = 1; oe_n = 0;
    repeat (len) @(negedge clk);
    idle(2);
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 stb", stb, 0); chk("R1 done", done, 0);
    chk("R1 sel", isel, 0); chk("R1 rdwr", rd | wr | slf, 0);
    rst_n = 1;
    idle(10);
    oe_n = 0; @(negedge clk);             // restarts the wait
    idle(PWR + 3);
    for (int i = 0; i < DUM - 1; i++) access(2, 15'(i), 1);
    chk("R2 not done early", done, 0);
    access(2, 15'h0, 1);
    chk("R2 done", done, 1);
    // R8 one-register latency
    @(negedge clk); cs_n = 0; we_n = 0; addr = 15'h1234;
    #1 chk("R8 before edge", wr, 0);
    @(negedge clk) chk("R8 after edge", wr, 1);
    idle(2);
    access(0, 15'h7f3a, 3);
    access(1, 15'h0155, 2);
    access(2, 15'h40c2, 1);
    for (int i = 0; i < 5; i++) refresh(3);
    // R7 hold-off: read, then cs rises with pin low
    cs_n = 0; we_n = 1; oe_n = 0; addr = 15'h00aa;
    repeat (3) @(negedge clk);
    cs_n = 1; repeat (3) @(negedge clk);
    idle(2);
    // R6 self refresh strobe count
    stb_cnt = 0;
    refresh(40);
    chk("R6 self strobes", stb_cnt, 1 + (40 - LONG + 1) / SINT);
    access(1, 15'h2211, 2);
    refresh(LONG - 1);
    for (int i = 0; i < 260; i++) refresh(1); // R5 wrap
    access(0, 15'h0001, 1);
    idle(4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule